// File: doc/BRIEF.md
# Dual Static and Rate-of-Change Alarm Unit

The block holds two independent alarm channels that watch a set of seven 14-bit measurement sources. All sources arrive as parallel buses, in a raw and a filtered version, and share one sample strobe. For each channel, a control word picks the source, whether the raw or the filtered copy is used, and whether the channel compares the sample value itself (static mode) or the mean change per sample over a window of N samples (rate mode). The channel's threshold word chooses the direction of the test with its top bit and holds the limit in its low 14 bits.

Each channel is evaluated once for every accepted sample and holds its result until the next one. The two alarm states are presented as status bits. They can also be routed, ORed together, to one of two indicator lines with programmable polarity. A line that the indicator does not select is left undriven, which the output-enable vector shows. The sample input is a valid/ready stream that never applies back-pressure: ready is held high and every valid cycle is one accepted sample.

Top module: `dual_alarm_unit`

## Requirements
- R1: Source code k from 1 to 7 selects bits [14k-1:14(k-1)] of the chosen source bus. The codes are 1 supply, 2 X acceleration, 3 Y acceleration, 4 temperature, 5 X incline, 6 Y incline and 7 rotation. Code 0 disables the channel, and a disabled channel's alarm is 0 after every accepted sample.
- R2: The filter-select bit (alm_ctrl_i[4] for alarm 1, [5] for alarm 2) picks src_filt_i when it is 1 and src_raw_i when it is 0.
- R3: Alarm 1 takes its source from alm_ctrl_i[10:8] and its rate enable from [11]. Alarm 2 takes its source from alm_ctrl_i[14:12] and its rate enable from [15].
- R4: In static mode the sample is compared with threshold bits [13:0]. Bit 15 of the threshold selects the test: 1 means sample > threshold and 0 means sample < threshold. Bit 14 is ignored. Codes 1 and 4 compare unsigned; all other codes compare as two's complement.
- R5: In rate mode the alarm is computed from y(k) − y(k−N) against N × threshold, which is the same as the mean of the N successive differences against the threshold. The threshold [13:0] is then always two's complement. Bit 15 still selects greater-than or less-than.
- R6: N is the channel's 8-bit count input. A count of 0 and a count of 1 both mean N = 1.
- R7: In rate mode the alarm stays 0 until N samples have been captured since reset or since the last change of that channel's source or filter selection.
- R8: smp_ready_o is always 1. The alarms update only on the clock edge that accepts a sample (valid and ready), appear in the following cycle, and hold otherwise.
- R9: alarm_o[0] is alarm 1 (status bit 8 of a status word) and alarm_o[1] is alarm 2 (status bit 9). The two channels do not affect each other.
- R10: Indicator control bits: alm_ctrl_i[2] enables it, [1] sets the polarity (1 = active high) and [0] selects the line (1 = line 2, 0 = line 1). When it is enabled, only the selected line has its enable set, and that line is active whenever either alarm is 1. When it is disabled, ind_oe_o is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe (stream valid) |
| smp_ready_o | output | 1 | Stream ready, held at 1 |
| src_raw_i | input | 98 | Seven packed raw 14-bit sources |
| src_filt_i | input | 98 | Seven packed filtered 14-bit sources |
| alm_ctrl_i | input | 16 | Alarm control word |
| alm1_thr_i | input | 16 | Alarm 1 threshold and direction |
| alm2_thr_i | input | 16 | Alarm 2 threshold and direction |
| alm1_cnt_i | input | 8 | Alarm 1 rate window length |
| alm2_cnt_i | input | 8 | Alarm 2 rate window length |
| alarm_o | output | 2 | Alarm states (bit 0 alarm 1, bit 1 alarm 2) |
| ind_o | output | 2 | Indicator line levels |
| ind_oe_o | output | 2 | Indicator line drive enables |

## Verification
The assertions assume that reset is applied before the first sample. They also assume that the control word and source buses carry known values whenever a sample is accepted, because the disabled-channel check reads the source field in the same cycle as the strobe. The bench changes configuration and source data only at falling clock edges and raises valid for exactly one cycle per sample. Configuration is therefore stable around every accepting edge. Each rate scenario also starts with a disabled-source sample, which resets the window state on purpose before the channel is enabled.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int REG_W   = 16;
  localparam int DATA_W  = 14;
  localparam int NUM_SRC = 7;
  localparam int CNT_W   = 8;

  typedef enum logic [2:0] {
    SRC_OFF    = 3'd0,
    SRC_SUPPLY = 3'd1,
    SRC_XACC   = 3'd2,
    SRC_YACC   = 3'd3,
    SRC_TEMP   = 3'd4,
    SRC_XINC   = 3'd5,
    SRC_YINC   = 3'd6,
    SRC_ROT    = 3'd7
  } src_e;

  // Binary-format sources compare unsigned, the rest as two's complement
  function automatic logic src_is_signed(input logic [2:0] code);
    return !(code == SRC_SUPPLY || code == SRC_TEMP);
  endfunction
endpackage

// File: rtl/alarm_src_mux.sv
module alarm_src_mux #(
  parameter int DW   = 14,
  parameter int NSRC = 7
) (
  input  logic [2:0]         src_sel,
  input  logic               filt_sel,
  input  logic [DW*NSRC-1:0] raw_bus,
  input  logic [DW*NSRC-1:0] filt_bus,
  output logic [DW-1:0]      value
);
  always_comb begin
    value = '0;
    for (int k = 1; k <= NSRC; k++) begin
      if (src_sel == 3'(k))
        value = filt_sel ? filt_bus[(k-1)*DW +: DW] : raw_bus[(k-1)*DW +: DW];
    end
  end
endmodule

// File: rtl/alarm_window.sv
module alarm_window #(
  parameter int DW = 14,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          fresh,
  input  logic [DW-1:0] value,
  input  logic [NW-1:0] n_eff,
  output logic [DW-1:0] old_value,
  output logic          warm
);
  localparam int DEPTH = 2 ** NW;
  localparam logic [NW:0] FILL_MAX = (NW+1)'(DEPTH - 1);

  logic [DW-1:0] hist [DEPTH];
  logic [NW-1:0] wptr;
  logic [NW:0]   fill;

  assign old_value = hist[wptr - n_eff];
  assign warm      = !fresh && (fill >= {1'b0, n_eff});

  always_ff @(posedge clk) begin
    if (take) hist[wptr] <= value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else if (take) begin
      wptr <= wptr + 1'b1;
      if (fresh)                fill <= (NW+1)'(1);
      else if (fill != FILL_MAX) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare #(
  parameter int DW = 14,
  parameter int NW = 8
) (
  input  logic          rate_mode,
  input  logic          is_signed,
  input  logic          gt_sel,
  input  logic [DW-1:0] thr_val,
  input  logic [DW-1:0] new_v,
  input  logic [DW-1:0] old_v,
  input  logic [NW-1:0] n_eff,
  output logic          hit
);
  localparam int PW = DW + NW + 2;

  logic signed [PW-1:0] ext_new, ext_old, thr_st, thr_rt, n_s, lhs, rhs;

  always_comb begin
    ext_new = {{(PW-DW){is_signed & new_v[DW-1]}}, new_v};
    ext_old = {{(PW-DW){is_signed & old_v[DW-1]}}, old_v};
    thr_st  = {{(PW-DW){is_signed & thr_val[DW-1]}}, thr_val};
    thr_rt  = {{(PW-DW){thr_val[DW-1]}}, thr_val};
    n_s     = {{(PW-NW){1'b0}}, n_eff};
    if (rate_mode) begin
      lhs = ext_new - ext_old;
      rhs = thr_rt * n_s;
    end else begin
      lhs = ext_new;
      rhs = thr_st;
    end
    hit = gt_sel ? (lhs > rhs) : (lhs < rhs);
  end
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
  import alarm_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NSRC = NUM_SRC,
  parameter int NW   = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [2:0]         src_sel,
  input  logic               filt_sel,
  input  logic               rate_en,
  input  logic               gt_sel,
  input  logic [DW-1:0]      thr_val,
  input  logic [NW-1:0]      cnt,
  input  logic [DW*NSRC-1:0] raw_bus,
  input  logic [DW*NSRC-1:0] filt_bus,
  output logic               alarm
);
  logic [DW-1:0] cur_v, old_v;
  logic [NW-1:0] n_eff;
  logic [3:0]    sel_q;
  logic          fresh, warm, hit;

  assign n_eff = (cnt == '0) ? NW'(1) : cnt;
  assign fresh = {filt_sel, src_sel} != sel_q;

  alarm_src_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
    .src_sel(src_sel), .filt_sel(filt_sel),
    .raw_bus(raw_bus), .filt_bus(filt_bus), .value(cur_v)
  );

  alarm_window #(.DW(DW), .NW(NW)) u_win (
    .clk(clk), .rst_n(rst_n), .take(take), .fresh(fresh),
    .value(cur_v), .n_eff(n_eff), .old_value(old_v), .warm(warm)
  );

  alarm_compare #(.DW(DW), .NW(NW)) u_cmp (
    .rate_mode(rate_en), .is_signed(src_is_signed(src_sel)), .gt_sel(gt_sel),
    .thr_val(thr_val), .new_v(cur_v), .old_v(old_v), .n_eff(n_eff), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      alarm <= 1'b0;
    end else if (take) begin
      sel_q <= {filt_sel, src_sel};
      if (src_sel == SRC_OFF) alarm <= 1'b0;
      else if (!rate_en)      alarm <= hit;
      else                    alarm <= warm & hit;
    end
  end
endmodule

// File: rtl/alarm_indicator.sv
module alarm_indicator (
  input  logic [1:0] alarms,
  input  logic       enable,
  input  logic       act_high,
  input  logic       line_sel,
  output logic [1:0] level,
  output logic [1:0] drive
);
  logic active;
  assign active = |alarms;

  always_comb begin
    drive = 2'b00;
    level = 2'b00;
    if (enable) begin
      drive[line_sel] = 1'b1;
      level[line_sel] = active ? act_high : !act_high;
    end
  end
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import alarm_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NSRC = NUM_SRC,
  parameter int NW   = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid_i,
  output logic               smp_ready_o,
  input  logic [DW*NSRC-1:0] src_raw_i,
  input  logic [DW*NSRC-1:0] src_filt_i,
  input  logic [REG_W-1:0]   alm_ctrl_i,
  input  logic [REG_W-1:0]   alm1_thr_i,
  input  logic [REG_W-1:0]   alm2_thr_i,
  input  logic [NW-1:0]      alm1_cnt_i,
  input  logic [NW-1:0]      alm2_cnt_i,
  output logic [1:0]         alarm_o,
  output logic [1:0]         ind_o,
  output logic [1:0]         ind_oe_o
);
  localparam int NCH = 2;

  logic             take;
  logic [REG_W-1:0] thr_a [NCH];
  logic [NW-1:0]    cnt_a [NCH];
  logic             unused_bits;

  assign smp_ready_o = 1'b1;
  assign take        = smp_valid_i & smp_ready_o;
  assign thr_a[0]    = alm1_thr_i;
  assign thr_a[1]    = alm2_thr_i;
  assign cnt_a[0]    = alm1_cnt_i;
  assign cnt_a[1]    = alm2_cnt_i;
  assign unused_bits = ^{alm_ctrl_i[7:6], alm_ctrl_i[3], alm1_thr_i[14], alm2_thr_i[14]};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    alarm_channel #(.DW(DW), .NSRC(NSRC), .NW(NW)) u_ch (
      .clk(clk), .rst_n(rst_n), .take(take),
      .src_sel(alm_ctrl_i[8+4*ch +: 3]),
      .filt_sel(alm_ctrl_i[4+ch]),
      .rate_en(alm_ctrl_i[11+4*ch]),
      .gt_sel(thr_a[ch][REG_W-1]),
      .thr_val(thr_a[ch][DW-1:0]),
      .cnt(cnt_a[ch]),
      .raw_bus(src_raw_i), .filt_bus(src_filt_i),
      .alarm(alarm_o[ch])
    );
  end

  alarm_indicator u_ind (
    .alarms(alarm_o), .enable(alm_ctrl_i[2]), .act_high(alm_ctrl_i[1]),
    .line_sel(alm_ctrl_i[0]), .level(ind_o), .drive(ind_oe_o)
  );
endmodule

// File: rtl/alarm_checker.sv
module alarm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       take,
  input logic [2:0] src1,
  input logic [2:0] src2,
  input logic       ind_en,
  input logic       ind_pol,
  input logic       ind_sel,
  input logic [1:0] alarm,
  input logic [1:0] ind,
  input logic [1:0] ind_oe
);
  assert_disabled_ch1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src1 == 3'd0) |=> !alarm[0]);

  assert_disabled_ch2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src2 == 3'd0) |=> !alarm[1]);

  assert_hold_between_samples_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(alarm));

  assert_ind_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_en |-> ind_oe == 2'b00);

  assert_ind_single_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ind_oe));

  assert_ind_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_en && ind_oe[ind_sel]) |-> (ind[ind_sel] == ((|alarm) ~^ ind_pol)));
endmodule

bind dual_alarm_unit alarm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .take(smp_valid_i & smp_ready_o),
  .src1(alm_ctrl_i[10:8]), .src2(alm_ctrl_i[14:12]),
  .ind_en(alm_ctrl_i[2]), .ind_pol(alm_ctrl_i[1]), .ind_sel(alm_ctrl_i[0]),
  .alarm(alarm_o), .ind(ind_o), .ind_oe(ind_oe_o)
);

// File: tb/sim_dual_alarm_unit.sv
module sim_dual_alarm_unit;
  localparam int DW = 14;
  localparam int NS = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [DW*NS-1:0] raw = '0, filt = '0;
  logic [15:0] ctrl = '0, thr1 = '0, thr2 = '0;
  logic [7:0]  cnt1 = 8'd1, cnt2 = 8'd1;
  logic [1:0]  alarm, ind, ind_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_alarm_unit u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_ready_o(smp_ready),
    .src_raw_i(raw), .src_filt_i(filt), .alm_ctrl_i(ctrl),
    .alm1_thr_i(thr1), .alm2_thr_i(thr2), .alm1_cnt_i(cnt1), .alm2_cnt_i(cnt2),
    .alarm_o(alarm), .ind_o(ind), .ind_oe_o(ind_oe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(int code, int val, bit to_filt);
    if (to_filt) filt[(code-1)*DW +: DW] = DW'(val);
    else         raw[(code-1)*DW +: DW]  = DW'(val);
  endtask

  task automatic strobe();
    @(negedge clk) smp_valid = 1'b1;
    @(negedge clk) smp_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reset alarms", {14'd0, alarm}, 16'h0);
    check("R10 reset indicator undriven", {14'd0, ind_oe}, 16'h0);
    check("R8 ready", {15'd0, smp_ready}, 16'h1);
  endtask

  task automatic t_static_signed();
    ctrl = 16'h0200;                       // alarm 1: X acceleration, static
    thr1 = {1'b1, 1'b0, 14'd100};
    put(2, 150, 0); strobe();
    check("R4 signed greater hit", {14'd0, alarm}, 16'h1);
    put(2, -5, 0); strobe();
    check("R4 signed negative below", {14'd0, alarm}, 16'h0);
    thr1 = {1'b0, 1'b1, 14'h3FF6};         // less than -10, bit 14 set (ignored)
    put(2, -20, 0); strobe();
    check("R4 less-than negative, bit14 ignored", {14'd0, alarm}, 16'h1);
    put(3, -20, 0); put(2, 0, 0); strobe();
    check("R1 slice isolation", {14'd0, alarm}, 16'h0);
  endtask

  task automatic t_static_unsigned();
    ctrl = 16'h0100;                       // alarm 1: supply, unsigned
    thr1 = {1'b1, 1'b0, 14'd100};
    put(1, 14'h3000, 0); strobe();
    check("R4 unsigned large value", {14'd0, alarm}, 16'h1);
    ctrl = 16'h0200; put(2, 14'h3000, 0); strobe();
    check("R4 same bits signed", {14'd0, alarm}, 16'h0);
  endtask

  task automatic t_filter_and_channel2();
    ctrl = 16'h3020;                       // alarm 2: Y accel filtered, alarm 1 off
    thr2 = {1'b1, 1'b0, 14'd400};
    put(3, 0, 0); put(3, 500, 1); strobe();
    check("R2 filtered copy used", {14'd0, alarm}, 16'h2);
    ctrl = 16'h3000; strobe();
    check("R2 raw copy used", {14'd0, alarm}, 16'h0);
    ctrl = 16'h3200; put(2, 150, 0); put(3, 500, 0); thr1 = {1'b1, 1'b0, 14'd100};
    strobe();
    check("R9 both channels", {14'd0, alarm}, 16'h3);
    thr1 = {1'b1, 1'b0, 14'd200}; strobe();
    check("R9 channels independent", {14'd0, alarm}, 16'h2);
  endtask

  task automatic t_disabled_and_hold();
    ctrl = 16'h0200; thr1 = {1'b1, 1'b0, 14'd100}; put(2, 150, 0); strobe();
    put(2, 0, 0);
    repeat (3) @(negedge clk);
    check("R8 hold without strobe", {14'd0, alarm}, 16'h1);
    ctrl = 16'h0000; put(2, 150, 0); strobe();
    check("R1 disabled never asserts", {14'd0, alarm}, 16'h0);
  endtask

  task automatic t_rate(string req, int n, int step, logic [15:0] thr, bit exp_hit);
    ctrl = 16'h0000; strobe();             // restart window state
    ctrl = 16'h0D00;                       // alarm 1: rate, X incline
    cnt1 = 8'(n); thr1 = thr;
    begin
      int neff;
      neff = (n == 0) ? 1 : n;
      for (int j = 0; j <= neff; j++) begin
        put(5, j * step, 0); strobe();
        if (j < neff) check({req, " R7 warm-up quiet"}, {14'd0, alarm}, 16'h0);
        else          check(req, {14'd0, alarm}, {15'd0, exp_hit});
      end
    end
  endtask

  task automatic t_indicator();
    ctrl = 16'h0204; thr1 = {1'b1, 1'b0, 14'd100}; put(2, 150, 0); strobe();
    ctrl = 16'h0206; #1;
    check("R10 line1 active high oe", {14'd0, ind_oe}, 16'h1);
    check("R10 line1 active high level", {15'd0, ind[0]}, 16'h1);
    ctrl = 16'h0204; #1;
    check("R10 active low level", {15'd0, ind[0]}, 16'h0);
    ctrl = 16'h0207; #1;
    check("R10 line2 select", {14'd0, ind_oe}, 16'h2);
    check("R10 line2 level", {15'd0, ind[1]}, 16'h1);
    put(2, 0, 0); strobe();
    ctrl = 16'h0205; #1;
    check("R10 idle active low", {15'd0, ind[1]}, 16'h1);
    ctrl = 16'h0203; #1;
    check("R10 disabled undriven", {14'd0, ind_oe}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_static_signed();
    t_static_unsigned();
    t_filter_and_channel2();
    t_disabled_and_hold();
    t_rate("R5 R3 mean 3 above 2", 4, 3, {1'b1, 1'b0, 14'd2}, 1'b1);
    t_rate("R5 mean 2 not above 2", 4, 2, {1'b1, 1'b0, 14'd2}, 1'b0);
    t_rate("R6 count 0 means one", 0, 3, {1'b1, 1'b0, 14'd2}, 1'b1);
    t_rate("R6 count 1", 1, 3, {1'b1, 1'b0, 14'd2}, 1'b1);
    t_rate("R5 falling below -1", 1, -2, {1'b0, 1'b0, 14'h3FFF}, 1'b1);
    t_indicator();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule